// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block turns single-word requests from a processor-side port into DRAM bus cycles on a multiplexed address bus, with row and column strobes. An access to a closed row runs four phases. First comes a precharge phase with the row strobe high. Next comes a row phase that presents the row address and lowers the row strobe. Two column phases follow: a setup phase, then a strobe phase with the column strobe low. Between the two column phases the sequencer can insert zero to three wait cycles.

When page operation is enabled, the row stays open after an access. If the next request arrives back to back and falls in the same row, it runs only the two column phases with a new column address. A request to another row, a request made after page operation is switched off, or a cycle with no request closes the page. The column width is selected as 8, 9, 10 or 11 bits. On a 16-bit data bus the lowest address bit selects a byte and is skipped. These two settings decide which address bits form the row that is compared.

The requester presents a request and holds it until the completion pulse. It may present the next request in the cycle right after that pulse. A read's data appears on the read-data output from the cycle after the completion pulse.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, row strobe, column strobe and write enable are high (inactive), the data bus driver is off and the completion pulse is low.
- R2: A request that finds no open page completes 5 + W cycles after it is presented, where W is the wait setting. The phases are precharge (row strobe high), row (row strobe falls, row address on the pins), column setup, then column strobe.
- R3: With selection value S (0..3), the column width is C = 8 + S and the byte offset B is 1 on a 16-bit bus, 0 otherwise. The column pins carry address bits [B+C-1:B]. The row pins carry the address shifted right by C + B.
- R4: With page operation on, a request presented in the cycle after a completion pulse whose row equals the open row completes in 2 + W cycles, and the row strobe does not go high in between.
- R5: A request to a different row while a page is open raises the row strobe, goes through precharge and row again, and completes in 5 + W cycles.
- R6: With page operation off, every access is a full access of 5 + W cycles, even for the same row.
- R7: A cycle without a request after a completion closes the page, so the following request is a full access.
- R8: W (0..3) extra cycles are inserted between column setup and column strobe, with the column strobe high during them.
- R9: The column strobe is low for exactly one cycle per access, and only while the row strobe is low.
- R10: During a write's column strobe, write enable is low, the data driver is on and the write data is on the bus. For a read, write enable is high and the driver is off.
- R11: Read data present on the bus at the end of the column strobe cycle appears on the read-data output from the next cycle on.
- R12: The completion pulse lasts one cycle per access and coincides with the column strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| cfg_page_en | input | 1 | Enables keeping a page open between accesses |
| cfg_col_sel | input | 2 | Column width select, C = 8 + value |
| cfg_wide_bus | input | 1 | 1 = 16-bit bus (address bit 0 is a byte select) |
| cfg_wait | input | 2 | Wait cycles between column setup and strobe |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data of the last read |
| mem_addr | output | PIN_W | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data returned from memory |

## Verification
The bench uses the defaults: a 20-bit address, 16-bit data and 12 address pins. The widest row field, with an 8-bit column on a byte bus, therefore fits the pins. All four column widths and both bus widths can be mixed with no row truncation. A memory model on the bench side stores by row and column pins. A mapping error therefore shows up as wrong read data as well as a wrong pin value. Addresses are drawn mostly from three rows, which makes same-row hits, row misses, idle gaps and switches of page mode frequent under every wait setting.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ROW  = 3'd2,
    PH_CSET = 3'd3,
    PH_WAIT = 3'd4,
    PH_CSTB = 3'd5
  } phase_e;

  // column width: 8 + select
  function automatic logic [4:0] col_bits(input logic [1:0] sel);
    return 5'd8 + {3'd0, sel};
  endfunction

endpackage

// File: rtl/dpc_addr_split.sv
module dpc_addr_split
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PIN_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        col_sel,
  input  logic              wide_bus,
  output logic [ADDR_W-1:0] row_full,
  output logic [PIN_W-1:0]  row_pins,
  output logic [PIN_W-1:0]  col_pins
);

  logic [4:0]        cw;
  logic [4:0]        row_shift;
  logic [ADDR_W-1:0] col_mask;
  logic [ADDR_W-1:0] col_full;

  always_comb begin
    cw        = col_bits(col_sel);
    row_shift = cw + {4'd0, wide_bus};
    col_mask  = ~({ADDR_W{1'b1}} << cw);
    row_full  = addr >> row_shift;
    col_full  = (addr >> wide_bus) & col_mask;
    row_pins  = row_full[PIN_W-1:0];
    col_pins  = col_full[PIN_W-1:0];
  end

endmodule

// File: rtl/dpc_page_track.sv
module dpc_page_track #(
  parameter int ROW_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic             set_open,
  input  logic             clr_open,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit,
  output logic             page_open
);

  logic [ROW_W-1:0] row_q, row_d;
  logic             open_q, open_d;

  always_comb begin
    row_d  = load ? load_row : row_q;
    open_d = open_q;
    if (clr_open) open_d = 1'b0;
    if (set_open) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      open_q <= 1'b0;
    end else begin
      row_q  <= row_d;
      open_q <= open_d;
    end
  end

  assign hit       = open_q && (probe_row == row_q);
  assign page_open = open_q;

endmodule

// File: rtl/dpc_wait_ctr.sv
module dpc_wait_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = ({1'b0, cnt_q} + 1'b1) == {1'b0, limit};

  // R8: a wait cycle only runs while fewer than the requested count have passed
  a_r8_wait_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q < limit));

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int PIN_W  = 12,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_col_sel,
  input  logic              cfg_wide_bus,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [PIN_W-1:0]  mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_e            ph_q, ph_d;
  logic              cont_q, cont_d;     // current setup phase continues an open page
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic              cur_wr_q, cur_wr_d;
  logic [DATA_W-1:0] cur_wd_q, cur_wd_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              take;

  logic [ADDR_W-1:0] req_row, cur_row;
  logic [PIN_W-1:0]  req_row_pins, req_col_pins, cur_row_pins, cur_col_pins;
  logic              row_hit, page_open, wait_last;
  logic              set_open, clr_open;

  dpc_addr_split #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_split_req (
    .addr(req_addr), .col_sel(cfg_col_sel), .wide_bus(cfg_wide_bus),
    .row_full(req_row), .row_pins(req_row_pins), .col_pins(req_col_pins)
  );

  dpc_addr_split #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_split_cur (
    .addr(cur_addr_q), .col_sel(cfg_col_sel), .wide_bus(cfg_wide_bus),
    .row_full(cur_row), .row_pins(cur_row_pins), .col_pins(cur_col_pins)
  );

  dpc_page_track #(.ROW_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_sync_n),
    .load(take), .load_row(req_row),
    .set_open(set_open), .clr_open(clr_open),
    .probe_row(req_row), .hit(row_hit), .page_open(page_open)
  );

  dpc_wait_ctr #(.CNT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_sync_n),
    .clear(ph_q == PH_CSET), .step(ph_q == PH_WAIT),
    .limit(cfg_wait), .last(wait_last)
  );

  // next-state logic
  always_comb begin
    ph_d   = ph_q;
    cont_d = 1'b0;
    take   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          take = 1'b1;
          ph_d = PH_PRE;
        end
      end
      PH_PRE: ph_d = PH_ROW;
      PH_ROW: ph_d = PH_CSET;
      PH_CSET: begin
        if (cont_q && !req_valid) begin
          ph_d = PH_IDLE;
        end else if (cont_q && !(row_hit && cfg_page_en)) begin
          take = 1'b1;
          ph_d = PH_PRE;
        end else begin
          take = cont_q;
          ph_d = (cfg_wait == '0) ? PH_CSTB : PH_WAIT;
        end
      end
      PH_WAIT: if (wait_last) ph_d = PH_CSTB;
      PH_CSTB: begin
        if (cfg_page_en) begin
          ph_d   = PH_CSET;
          cont_d = 1'b1;
        end else begin
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    set_open = (ph_q == PH_PRE);
    clr_open = (ph_q != PH_PRE) && ((ph_d == PH_IDLE) || (ph_d == PH_PRE));

    cur_addr_d = take ? req_addr  : cur_addr_q;
    cur_wr_d   = take ? req_write : cur_wr_q;
    cur_wd_d   = take ? req_wdata : cur_wd_q;
    rdata_d    = ((ph_q == PH_CSTB) && !cur_wr_q) ? mem_dq_in : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q       <= PH_IDLE;
      cont_q     <= 1'b0;
      cur_addr_q <= '0;
      cur_wr_q   <= 1'b0;
      cur_wd_q   <= '0;
      rdata_q    <= '0;
    end else begin
      ph_q       <= ph_d;
      cont_q     <= cont_d;
      cur_addr_q <= cur_addr_d;
      cur_wr_q   <= cur_wr_d;
      cur_wd_q   <= cur_wd_d;
      rdata_q    <= rdata_d;
    end
  end

  // output decode
  logic drive_phase;
  always_comb begin
    drive_phase = (ph_q == PH_WAIT) || (ph_q == PH_CSTB);
    unique case (ph_q)
      PH_PRE, PH_ROW: mem_addr = cur_row_pins;
      PH_CSET:        mem_addr = cont_q ? req_col_pins : cur_col_pins;
      PH_WAIT,
      PH_CSTB:        mem_addr = cur_col_pins;
      default:        mem_addr = '0;
    endcase
  end

  assign mem_ras_n  = ~page_open;
  assign mem_cas_n  = ~(ph_q == PH_CSTB);
  assign mem_we_n   = ~(drive_phase && cur_wr_q);
  assign mem_dq_oe  = drive_phase && cur_wr_q;
  assign mem_dq_out = cur_wd_q;
  assign rsp_done   = (ph_q == PH_CSTB);
  assign rsp_rdata  = rdata_q;

  // R9: column strobe only under an open row, one cycle at a time
  a_r9_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_cas_n |-> !mem_ras_n);
  a_r9_cas_one_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_cas_n |=> mem_cas_n);
  // R2: the cycle after the row strobe falls is a setup cycle, never a strobe
  a_r2_row_before_col: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(mem_ras_n) |=> mem_cas_n);
  // R5: the row closes only while the column strobe is inactive
  a_r5_close_without_cas: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_ras_n) |-> mem_cas_n);
  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          cfg_page_en, cfg_wide_bus;
  logic [1:0]    cfg_col_sel, cfg_wait;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [PW-1:0] mem_addr;
  logic          mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  always #10 clk = ~clk;   // 50 MHz

  dram_page_seq u_dram_page_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .cfg_page_en(cfg_page_en), .cfg_col_sel(cfg_col_sel), .cfg_wide_bus(cfg_wide_bus),
    .cfg_wait(cfg_wait),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fill_pat(input logic [23:0] key);
    return key[15:0] ^ {key[23:20], key[11:0]} ^ 16'hA5C3;
  endfunction

  function automatic int cwidth(input logic [1:0] sel);
    return 8 + int'(sel);
  endfunction
  function automatic logic [AW-1:0] row_of(input logic [AW-1:0] a, input logic [1:0] sel, input bit wide);
    return a >> (cwidth(sel) + int'(wide));
  endfunction
  function automatic logic [PW-1:0] col_of(input logic [AW-1:0] a, input logic [1:0] sel, input bit wide);
    logic [AW-1:0] m;
    m = (AW'(1) << cwidth(sel)) - 1;
    return PW'((a >> int'(wide)) & m);
  endfunction

  // memory model on the pin side
  logic [DW-1:0] dram_cells [logic [23:0]];
  logic [DW-1:0] shadow     [logic [23:0]];
  logic [PW-1:0] latched_row = '0;
  bit            prev_ras = 1'b1;
  int  mon_ras_fall, mon_cas, mon_done_total = 0;
  logic [PW-1:0] mon_row, mon_col;
  bit  mon_we_n, mon_oe, mon_cas_ras_ok;
  logic [DW-1:0] mon_dq;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ras_n && prev_ras) begin
        mon_ras_fall++;
        mon_row     = mem_addr;
        latched_row = mem_addr;
      end
      if (!mem_cas_n) begin
        mon_cas++;
        mon_col        = mem_addr;
        mon_we_n       = mem_we_n;
        mon_oe         = mem_dq_oe;
        mon_dq         = mem_dq_out;
        mon_cas_ras_ok = !mem_ras_n;
        if (!mem_we_n) dram_cells[{latched_row, mem_addr}] = mem_dq_out;
        else mem_dq_in = dram_cells.exists({latched_row, mem_addr}) ?
                         dram_cells[{latched_row, mem_addr}] : fill_pat({latched_row, mem_addr});
      end
      if (rsp_done) mon_done_total++;
      prev_ras = mem_ras_n;
    end
  end

  // reference state
  bit            ref_open = 1'b0;
  logic [AW-1:0] ref_row  = '0;
  int            n_access = 0;
  bit            hung = 1'b0;

  task automatic access(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d);
    bit            hit;
    int            lat, exp_lat;
    logic [AW-1:0] r;
    logic [PW-1:0] c;
    logic [23:0]   key;
    logic [DW-1:0] exp_rd;
    r   = row_of(a, cfg_col_sel, cfg_wide_bus);
    c   = col_of(a, cfg_col_sel, cfg_wide_bus);
    key = {r[PW-1:0], c};
    hit = ref_open && cfg_page_en && (r == ref_row);
    exp_lat = (hit ? 2 : 5) + int'(cfg_wait);
    mon_ras_fall = 0; mon_cas = 0;
    req_addr = a; req_write = wr; req_wdata = d; req_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rsp_done && lat < 60);
    if (!rsp_done) hung = 1'b1;
    // R2 R4 R5 R6 R8: cycle count (2 or 5) + waits
    chk(lat == exp_lat, hit ? "R4 R8 page-hit latency" : "R2 R5 R6 R8 full latency", lat, exp_lat);
    chk(!mem_cas_n, "R12 done with cas", mem_cas_n, 0);
    @(posedge clk); #1;
    n_access++;
    chk(mon_cas == 1, "R9 R8 one cas cycle", mon_cas, 1);
    chk(mon_cas_ras_ok, "R9 cas under ras", mon_cas_ras_ok, 1);
    chk(mon_col == c, "R3 column pins", mon_col, c);
    if (hit) chk(mon_ras_fall == 0, "R4 row strobe held", mon_ras_fall, 0);
    else begin
      chk(mon_ras_fall == 1, "R2 R5 one row phase", mon_ras_fall, 1);
      chk(mon_row == r[PW-1:0], "R3 row pins", mon_row, r[PW-1:0]);
    end
    if (wr) begin
      chk(!mon_we_n && mon_oe && mon_dq == d, "R10 write drive", {mon_we_n, mon_oe, mon_dq}, {1'b0, 1'b1, d});
      shadow[key] = d;
    end else begin
      exp_rd = shadow.exists(key) ? shadow[key] : fill_pat(key);
      chk(mon_we_n && !mon_oe, "R10 read no drive", {mon_we_n, mon_oe}, 2'b10);
      chk(rsp_rdata == exp_rd, "R11 read data", rsp_rdata, exp_rd);
    end
    ref_open = cfg_page_en;
    ref_row  = r;
  endtask

  task automatic gap();
    req_valid = 1'b0;
    @(posedge clk); #1;
    ref_open = 1'b0;
  endtask

  function automatic logic [AW-1:0] mk_addr(input int row, input int col, input bit bsel);
    int sh;
    sh = cwidth(cfg_col_sel) + int'(cfg_wide_bus);
    return AW'((row << sh) | (col << int'(cfg_wide_bus)) | (cfg_wide_bus ? int'(bsel) : 0));
  endfunction

  initial begin
    int unsigned seed;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_page_en = 1'b0; cfg_col_sel = 2'd0; cfg_wide_bus = 1'b0; cfg_wait = 2'd0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe && !rsp_done, "R1 reset outputs",
        {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe && !rsp_done, "R1 idle after reset",
        {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);
    @(posedge clk); #1;

    // R6: page mode off, same row stays full
    access(mk_addr(1, 5, 0), 1, 16'h1234);
    access(mk_addr(1, 6, 0), 0, 0);
    access(mk_addr(1, 5, 0), 0, 0);
    gap();
    // R4: page mode on, same-row run
    cfg_page_en = 1'b1;
    access(mk_addr(2, 1, 0), 1, 16'hBEEF);
    access(mk_addr(2, 2, 0), 1, 16'hCAFE);
    access(mk_addr(2, 1, 0), 0, 0);
    // R5: miss while open
    access(mk_addr(3, 2, 0), 0, 0);
    access(mk_addr(3, 9, 0), 1, 16'h0F0F);
    // R7: gap closes page
    gap();
    access(mk_addr(3, 9, 0), 0, 0);
    // R8: each wait setting, hit and full
    for (int w = 1; w < 4; w++) begin
      cfg_wait = 2'(w);
      access(mk_addr(3, w, 0), 1, 16'(w * 16'h111));
      access(mk_addr(3, w, 0), 0, 0);
    end
    gap();
    // R3: widest column, wide bus, top row
    cfg_wait = 2'd0; cfg_col_sel = 2'd3; cfg_wide_bus = 1'b1;
    access(mk_addr(255, 2047, 1), 1, 16'h7E57);
    access(mk_addr(255, 2047, 0), 0, 0);
    // page mode switched off while a page is open
    cfg_page_en = 1'b0;
    access(mk_addr(255, 2047, 0), 0, 0);
    gap();

    // random phase
    seed = $urandom(32'd2024);
    for (int i = 0; i < 400 && !hung; i++) begin
      int rw, cl;
      if ($urandom % 6 == 0) begin
        gap();
        cfg_col_sel  = 2'($urandom);
        cfg_wide_bus = 1'($urandom);
      end
      if ($urandom % 8 == 0) cfg_page_en = ~cfg_page_en;
      if ($urandom % 5 == 0) cfg_wait = 2'($urandom);
      rw = ($urandom % 5 == 0) ? int'($urandom % (1 << (AW - cwidth(cfg_col_sel) - int'(cfg_wide_bus))))
                               : int'($urandom % 3);
      cl = int'($urandom % (1 << cwidth(cfg_col_sel)));
      access(mk_addr(rw, cl, 1'($urandom)), 1'($urandom), 16'($urandom));
    end
    gap();
    chk(mon_done_total == n_access, "R12 one pulse per access", mon_done_total, n_access);
    chk(!hung, "watchdog", hung, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule